// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is a slave port that lets an external host read and write the internal memory of a processor. The host and the port share one multiplexed address/data bus. The host first loads a starting address into the port's address register. It then issues a stream of read or write strobes. Each accepted access takes exactly one memory cycle from the core, and after that cycle the address register advances by one. A ready line tells the host when the port can take another strobe. The core can read the address register and can load it directly. This lets the core choose the address while the host only moves data.

The address register is 14 bits wide by default and wraps from its top value to zero. Above it sits a memory-space select bit that the increment never changes. The block has an optional short-cycle mode for hosts that never wait on the ready line. In this mode the read data register works as a one-word prefetch buffer. Every address load fetches the word at the new address. Every read strobe returns the buffered word at once and fetches the next word. The memory array itself lies outside the block. The port drives a single-cycle memory port and arbitrates it against the core's request.

Top module: `hostmem_port`

## Requirements
- R1: After reset the ready line `hack` is 1, `hbus_out` is 0 and the address register reads 0. With no core request, `mem_en` is 0.
- R2: A strobe with `hsel` and `hlatch` high while `hack` is 1 loads the address register. Bits [ADDR_W-1:0] of `hbus_in` become the address and bit ADDR_W becomes the space bit. The new value shows on `creg_rdata` one cycle later. Outside short mode a load starts no memory access.
- R3: A normal read strobe (`hsel` and `hrd` high while `hack` is 1) drops `hack` in the next cycle. The port reads memory at the current address in that same cycle. In the third cycle after the strobe, `hack` is high again and `hbus_out` holds the word. While `hack` stays high, `hbus_out` does not change.
- R4: A write strobe (`hsel` and `hwr` high while `hack` is 1) writes `hbus_in` to memory at the current address in the next cycle. `hack` is low for exactly that one cycle.
- R5: Every host memory access increments the address by one, wrapping from 2^ADDR_W-1 to 0. The space bit stays unchanged.
- R6: The address register keeps its value through any number of idle cycles until the host or the core loads it.
- R7: A pulse on `creg_we` loads the address register from `creg_wdata`. A host address load in the same cycle takes priority.
- R8: A host access always wins the memory port. When `core_req` is high in that cycle, `core_stall` is high for that one cycle only. In every other cycle the memory port carries the core's request unchanged.
- R9: Strobes that arrive while `hack` is low are ignored. They cause no memory access and no address change.
- R10: With `short_mode` high, every address load (host or core) fetches the word at the new address into the read buffer, and the address advances. Every read strobe finds the buffered word already on `hbus_out` in the strobe cycle, and then fetches the next word. The host leaves at least three cycles between short strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_mode | input | 1 | Selects short cycles with read prefetch |
| hsel | input | 1 | Host select |
| hlatch | input | 1 | Host address-load strobe |
| hrd | input | 1 | Host read strobe |
| hwr | input | 1 | Host write strobe |
| hbus_in | input | DATA_W | Host bus, address or write data |
| hbus_out | output | DATA_W | Host read data / prefetch buffer |
| hack | output | 1 | Port ready (1) or busy (0) |
| core_req | input | 1 | Core memory request |
| core_we | input | 1 | Core write enable |
| core_addr | input | ADDR_W+1 | Core address including space bit |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Memory read data to the core |
| core_stall | output | 1 | Core request held off this cycle |
| creg_we | input | 1 | Core load of the address register |
| creg_wdata | input | ADDR_W+1 | Core value for the address register |
| creg_rdata | output | ADDR_W+1 | Address register, space bit on top |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W+1 | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the read |

## Verification
The bench targets the address wrap at the top of a space. A counter that carried into the space bit would send the third write to the other space, and the scoreboard would report the wrong address. It issues a second write strobe while the port is still busy. A port that accepted it would do an extra write, which the monitor sees as an unexpected transaction, and a later read would return the wrong word. It runs a host access during a continuous core request. This exposes a stall that lasts too long, or a memory port that fails to hand control back to the core. In short mode it checks that each strobe returns the word already prefetched. An off-by-one in the prefetch address would show up as a shifted data stream.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
   typedef enum logic [1:0] {
      HOP_IDLE  = 2'd0,
      HOP_LATCH = 2'd1,
      HOP_READ  = 2'd2,
      HOP_WRITE = 2'd3
   } host_op_e;
endpackage

// File: rtl/hmp_host_dec.sv
module hmp_host_dec
   import hmp_pkg::*;
(
   input  logic     hsel,
   input  logic     hlatch,
   input  logic     hrd,
   input  logic     hwr,
   input  logic     ready,
   output host_op_e op
);
   // strobes are only taken while the port reports ready (R9)
   always_comb begin
      op = HOP_IDLE;
      if (hsel && ready) begin
         if (hlatch)   op = HOP_LATCH;
         else if (hrd) op = HOP_READ;
         else if (hwr) op = HOP_WRITE;
      end
   end
endmodule

// File: rtl/hmp_addr_reg.sv
module hmp_addr_reg #(
   parameter int ADDR_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_host,
   input  logic [ADDR_W:0] host_val,
   input  logic            ld_core,
   input  logic [ADDR_W:0] core_val,
   input  logic            inc,
   output logic [ADDR_W:0] cur
);
   localparam logic [ADDR_W-1:0] STEP = 1;

   logic [ADDR_W-1:0] ofs;
   logic              spc;

   // host load over core load over increment (R7); offset wraps, space bit held (R5)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs <= '0;
         spc <= 1'b0;
      end else if (ld_host) begin
         ofs <= host_val[ADDR_W-1:0];
         spc <= host_val[ADDR_W];
      end else if (ld_core) begin
         ofs <= core_val[ADDR_W-1:0];
         spc <= core_val[ADDR_W];
      end else if (inc) begin
         ofs <= ofs + STEP;
      end
   end

   assign cur = {spc, ofs};
endmodule

// File: rtl/hmp_xfer.sv
module hmp_xfer
   import hmp_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter bit SHORT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  host_op_e          op,
   input  logic [DATA_W-1:0] hbus_in,
   input  logic              short_mode,
   input  logic              addr_load,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pend,
   output logic              pend_we,
   output logic [DATA_W-1:0] pend_data,
   output logic [DATA_W-1:0] rd_buf,
   output logic              busy
);
   logic short_eff;
   logic pf_req;
   logic rd_wait;

   generate
      if (SHORT_EN) begin : g_short
         assign short_eff = short_mode;
      end else begin : g_long
         logic unused_short;
         assign unused_short = short_mode;
         assign short_eff    = 1'b0;
      end
   endgenerate

   // in short mode an address load refills the buffer (R10)
   assign pf_req = short_eff && addr_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_we   <= 1'b0;
         pend_data <= '0;
         rd_wait   <= 1'b0;
         rd_buf    <= '0;
      end else begin
         pend    <= (op == HOP_READ) || (op == HOP_WRITE) || pf_req;
         pend_we <= (op == HOP_WRITE);
         if (op == HOP_WRITE) pend_data <= hbus_in;
         rd_wait <= pend && !pend_we;
         if (rd_wait) rd_buf <= mem_rdata;
      end
   end

   assign busy = pend || rd_wait;
endmodule

// File: rtl/hmp_arb.sv
module hmp_arb #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 14
) (
   input  logic              host_gnt,
   input  logic              host_we,
   input  logic [ADDR_W:0]   host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [ADDR_W:0]   core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic              core_stall,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   // host takes the cycle outright; core waits exactly that cycle (R8)
   always_comb begin
      mem_en     = host_gnt || core_req;
      core_stall = host_gnt && core_req;
      if (host_gnt) begin
         mem_we    = host_we;
         mem_addr  = host_addr;
         mem_wdata = host_wdata;
      end else begin
         mem_we    = core_req && core_we;
         mem_addr  = core_addr;
         mem_wdata = core_wdata;
      end
   end
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
   import hmp_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 14,
   parameter bit SHORT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              short_mode,
   input  logic              hsel,
   input  logic              hlatch,
   input  logic              hrd,
   input  logic              hwr,
   input  logic [DATA_W-1:0] hbus_in,
   output logic [DATA_W-1:0] hbus_out,
   output logic              hack,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [ADDR_W:0]   core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [DATA_W-1:0] core_rdata,
   output logic              core_stall,
   input  logic              creg_we,
   input  logic [ADDR_W:0]   creg_wdata,
   output logic [ADDR_W:0]   creg_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int CREG_W = ADDR_W + 1;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("hostmem_port: ADDR_W must be at least 1");
   end
   if (CREG_W > DATA_W) begin : g_bad_width
      $error("hostmem_port: address plus space bit must fit on the host bus");
   end

   host_op_e          op;
   logic              busy;
   logic              host_gnt;
   logic              pend_we;
   logic [DATA_W-1:0] pend_data;

   assign hack       = !busy;
   assign core_rdata = mem_rdata;

   hmp_host_dec u_dec (
      .hsel   (hsel),
      .hlatch (hlatch),
      .hrd    (hrd),
      .hwr    (hwr),
      .ready  (hack),
      .op     (op)
   );

   hmp_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_host  (op == HOP_LATCH),
      .host_val (hbus_in[CREG_W-1:0]),
      .ld_core  (creg_we),
      .core_val (creg_wdata),
      .inc      (host_gnt),
      .cur      (creg_rdata)
   );

   hmp_xfer #(.DATA_W(DATA_W), .SHORT_EN(SHORT_EN)) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .hbus_in    (hbus_in),
      .short_mode (short_mode),
      .addr_load  ((op == HOP_LATCH) || creg_we),
      .mem_rdata  (mem_rdata),
      .pend       (host_gnt),
      .pend_we    (pend_we),
      .pend_data  (pend_data),
      .rd_buf     (hbus_out),
      .busy       (busy)
   );

   hmp_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arb (
      .host_gnt   (host_gnt),
      .host_we    (pend_we),
      .host_addr  (creg_rdata),
      .host_wdata (pend_data),
      .core_req   (core_req),
      .core_we    (core_we),
      .core_addr  (core_addr),
      .core_wdata (core_wdata),
      .core_stall (core_stall),
      .mem_en     (mem_en),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata)
   );
endmodule

// File: rtl/hmp_checker.sv
module hmp_checker #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hsel,
   input logic              hlatch,
   input logic              hrd,
   input logic              hwr,
   input logic [DATA_W-1:0] hbus_in,
   input logic [DATA_W-1:0] hbus_out,
   input logic              hack,
   input logic              core_req,
   input logic              core_we,
   input logic [ADDR_W:0]   core_addr,
   input logic              core_stall,
   input logic              creg_we,
   input logic [ADDR_W:0]   creg_rdata,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W:0]   mem_addr,
   input logic              host_gnt
);
   assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hsel && hack && hlatch) |=> (creg_rdata == $past(hbus_in[ADDR_W:0])));

   assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hack && $past(hack)) |-> $stable(hbus_out));

   assert_busy_after_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hsel && hack && !hlatch && (hrd || hwr)) |=> !hack);

   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_gnt && !creg_we) |=>
         (creg_rdata[ADDR_W-1:0] == ADDR_W'($past(creg_rdata[ADDR_W-1:0]) + 1)));

   assert_space_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_gnt && !creg_we) |=> $stable(creg_rdata[ADDR_W]));

   assert_steal_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      core_stall |-> (core_req && mem_en && mem_addr == creg_rdata));

   assert_core_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && !core_stall) |->
         (mem_en && mem_addr == core_addr && mem_we == core_we));
endmodule

bind hostmem_port hmp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/hostmem_port_test.sv
`timescale 1ns/1ps
module hostmem_port_test;
   localparam int DW = 16;
   localparam int AW = 14;

   typedef struct packed {
      logic          we;
      logic [AW:0]   addr;
      logic [DW-1:0] data;
   } txn_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          short_mode = 1'b0;
   logic          hsel = 1'b0, hlatch = 1'b0, hrd = 1'b0, hwr = 1'b0;
   logic [DW-1:0] hbus_in = '0;
   logic [DW-1:0] hbus_out;
   logic          hack;
   logic          core_req = 1'b0, core_we = 1'b0;
   logic [AW:0]   core_addr = '0;
   logic [DW-1:0] core_wdata = '0;
   logic [DW-1:0] core_rdata;
   logic          core_stall;
   logic          creg_we = 1'b0;
   logic [AW:0]   creg_wdata = '0;
   logic [AW:0]   creg_rdata;
   logic          mem_en, mem_we;
   logic [AW:0]   mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   txn_t exp_q[$];
   logic [DW-1:0] ram [int];
   logic [DW-1:0] shadow [int];
   logic [AW:0] cur = '0;
   logic [AW:0] buf_a = '0;

   always #2 clk = ~clk;

   hostmem_port uut (.*);

   function automatic logic [DW-1:0] fill(input logic [AW:0] a);
      return DW'(a) * 16'd7 + 16'h1234;
   endfunction

   function automatic logic [DW-1:0] expect_word(input logic [AW:0] a);
      if (shadow.exists(int'(a))) return shadow[int'(a)];
      return fill(a);
   endfunction

   function automatic logic [AW:0] nxt(input logic [AW:0] a);
      return {a[AW], AW'(a[AW-1:0] + 1'b1)};
   endfunction

   // memory model, one-cycle read latency
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[int'(mem_addr)] = mem_wdata;
         else if (ram.exists(int'(mem_addr))) mem_rdata <= ram[int'(mem_addr)];
         else mem_rdata <= fill(mem_addr);
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: every host-owned memory cycle is matched against the queue
   always @(negedge clk) begin
      if (rst_n && mem_en && (!core_req || core_stall)) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R9 unexpected host cycle: actual %h expected none", mem_addr);
         end else begin
            txn_t e;
            e = exp_q.pop_front();
            check("R5", 32'(mem_addr), 32'(e.addr), "host cycle address");
            check("R4", 32'(mem_we), 32'(e.we), "host cycle direction");
            if (e.we) check("R4", 32'(mem_wdata), 32'(e.data), "host write data");
         end
      end
   end

   task automatic strobe(input logic l, input logic r, input logic w, input logic [DW-1:0] d);
      @(posedge clk); #1;
      hsel = 1'b1; hlatch = l; hrd = r; hwr = w; hbus_in = d;
      @(posedge clk); #1;
      hsel = 1'b0; hlatch = 1'b0; hrd = 1'b0; hwr = 1'b0;
   endtask

   task automatic wait_ready();
      while (!hack) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic host_latch(input logic sp, input logic [AW-1:0] a);
      cur = {sp, a};
      if (short_mode) begin
         exp_q.push_back('{1'b0, cur, '0});
         buf_a = cur;
      end
      strobe(1'b1, 1'b0, 1'b0, DW'({sp, a}));
      check("R2", 32'(creg_rdata), 32'({sp, a}), "latched address");
      if (short_mode) cur = nxt(cur);
      wait_ready();
   endtask

   task automatic host_write(input logic [DW-1:0] d);
      exp_q.push_back('{1'b1, cur, d});
      shadow[int'(cur)] = d;
      strobe(1'b0, 1'b0, 1'b1, d);
      check("R4", 32'(hack), 32'd0, "busy in write cycle");
      @(posedge clk); #1;
      check("R4", 32'(hack), 32'd1, "ready after one busy cycle");
      cur = nxt(cur);
   endtask

   task automatic host_read();
      logic [DW-1:0] e;
      e = expect_word(cur);
      exp_q.push_back('{1'b0, cur, '0});
      strobe(1'b0, 1'b1, 1'b0, '0);
      check("R3", 32'(hack), 32'd0, "busy first read cycle");
      @(posedge clk); #1;
      check("R3", 32'(hack), 32'd0, "busy second read cycle");
      @(posedge clk); #1;
      check("R3", 32'(hack), 32'd1, "ready third read cycle");
      check("R3", 32'(hbus_out), 32'(e), "read data");
      cur = nxt(cur);
   endtask

   task automatic short_read();
      @(posedge clk); #1;
      hsel = 1'b1; hrd = 1'b1;
      check("R10", 32'(hbus_out), 32'(expect_word(buf_a)), "short read buffered word");
      exp_q.push_back('{1'b0, cur, '0});
      buf_a = cur;
      cur = nxt(cur);
      @(posedge clk); #1;
      hsel = 1'b0; hrd = 1'b0;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic core_load(input logic [AW:0] v);
      cur = v;
      if (short_mode) begin
         exp_q.push_back('{1'b0, cur, '0});
         buf_a = cur;
         cur = nxt(cur);
      end
      @(posedge clk); #1;
      creg_we = 1'b1; creg_wdata = v;
      @(posedge clk); #1;
      creg_we = 1'b0;
      check("R7", 32'(creg_rdata), 32'(v), "core register load");
      wait_ready();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", 32'(hack), 32'd1, "ready after reset");
      check("R1", 32'(hbus_out), 32'd0, "bus out after reset");
      check("R1", 32'(creg_rdata), 32'd0, "address after reset");
      check("R1", 32'(mem_en), 32'd0, "memory idle after reset");

      // R2 R4 R3 R5 normal stream
      host_latch(1'b0, 14'h0010);
      host_write(16'hBEEF);
      host_write(16'h1357);
      host_write(16'hC0DE);
      check("R5", 32'(creg_rdata), 32'h0013, "address after three writes");
      host_latch(1'b0, 14'h0010);
      host_read();
      host_read();
      host_read();
      host_read();

      // R5 wrap with space bit set
      host_latch(1'b1, 14'h3FFE);
      host_write(16'hAAA1);
      host_write(16'hAAA2);
      host_write(16'hAAA3);
      check("R5", 32'(creg_rdata), 32'({1'b1, 14'h0001}), "wrapped address keeps space");
      host_latch(1'b1, 14'h3FFE);
      host_read();
      host_read();
      host_read();

      // R6 persistence over idle time
      host_latch(1'b0, 14'h0100);
      repeat (20) @(posedge clk);
      #1;
      check("R6", 32'(creg_rdata), 32'h0100, "address held while idle");
      host_read();

      // R7 core load, then host priority in the same cycle
      core_load({1'b0, 14'h0200});
      host_read();
      @(posedge clk); #1;
      hsel = 1'b1; hlatch = 1'b1; hbus_in = 16'h0300;
      creg_we = 1'b1; creg_wdata = 15'h0400;
      @(posedge clk); #1;
      hsel = 1'b0; hlatch = 1'b0; creg_we = 1'b0;
      check("R7", 32'(creg_rdata), 32'h0300, "host load wins over core load");
      cur = 15'h0300;

      // R8 cycle stealing against a steady core read
      core_req = 1'b1; core_we = 1'b0; core_addr = 15'h0555;
      @(posedge clk); #1;
      check("R8", 32'(mem_addr), 32'h0555, "core owns idle memory port");
      check("R8", 32'(core_stall), 32'd0, "no stall without host");
      exp_q.push_back('{1'b1, cur, 16'h7E7E});
      shadow[int'(cur)] = 16'h7E7E;
      strobe(1'b0, 1'b0, 1'b1, 16'h7E7E);
      check("R8", 32'(core_stall), 32'd1, "core stalled in stolen cycle");
      check("R8", 32'(mem_addr), 32'(cur), "host address in stolen cycle");
      cur = nxt(cur);
      @(posedge clk); #1;
      check("R8", 32'(core_stall), 32'd0, "stall lasts one cycle");
      check("R8", 32'(mem_addr), 32'h0555, "core regains memory port");
      core_req = 1'b0;

      // R9 strobe while busy is ignored
      host_latch(1'b0, 14'h0040);
      exp_q.push_back('{1'b1, cur, 16'h1111});
      shadow[int'(cur)] = 16'h1111;
      @(posedge clk); #1;
      hsel = 1'b1; hwr = 1'b1; hbus_in = 16'h1111;
      @(posedge clk); #1;
      check("R9", 32'(hack), 32'd0, "busy while second strobe offered");
      hbus_in = 16'h2222;
      @(posedge clk); #1;
      hsel = 1'b0; hwr = 1'b0;
      check("R9", 32'(hack), 32'd1, "only one access taken");
      check("R9", 32'(creg_rdata), 32'h0041, "address stepped once");
      host_latch(1'b0, 14'h0040);
      host_read();
      host_read();

      // R10 short mode with prefetch buffer
      short_mode = 1'b1;
      host_latch(1'b0, 14'h0010);
      short_read();
      short_read();
      short_read();
      core_load({1'b1, 14'h3FFF});
      short_read();
      short_read();
      short_mode = 1'b0;

      repeat (4) @(posedge clk);
      #1;
      check("R9", 32'(exp_q.size()), 32'd0, "all expected host cycles seen");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule